// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two IEEE 754 binary32 numbers and returns one binary32 product. It has two register stages. An operand pair presented with its valid bit produces a result two clock edges later, and the output valid bit marks that result. The block accepts a new operand pair on every cycle.

Each operand is first sorted into a 3-bit type code:

| Type | Code |
|------|------|
| zero | `000` |
| subnormal | `001` |
| normal | `10x` (built as `100`) |
| infinity | `110` |
| NaN | `111` |

Pairs that involve a zero, an infinity or a NaN bypass the arithmetic. A separate symbolic-result path builds their answer from the two type codes and the product sign.

Finite, non-zero pairs go through the arithmetic path in this order:

1. Multiply the two significands.
2. Add the two exponents.
3. Normalise the product.
4. Round to nearest, ties to even.

This path also produces overflow to infinity and gradual underflow into subnormals. No exception flags are raised. No other rounding mode is offered.

Top module: `fp_mult_sp`

## Requirements
- R1: While `rst_n` is low, `out_vld` and `out_res` are both 0.
- R2: `out_vld` at each clock edge equals `in_vld` from two edges earlier. `out_res` is the product of the operands presented with that `in_vld`.
- R3: For normal operands with an in-range result, `out_res` is the exact product rounded to nearest. The sign bit of the result is the XOR of the two operand signs.
- R4: When the exact product lies halfway between two representable values, the result is the one whose lowest fraction bit is 0.
- R5: An operand whose exponent field is 0 and whose fraction is non-zero has the value fraction·2^-149. This value is used exactly in the product.
- R6: If a rounded magnitude would reach 2^128 or more, the result is infinity with the product sign. Infinity is exponent field 255 and fraction 0.
- R7: Small products give a subnormal result (exponent field 0). Products smaller than half of 2^-149, and ties at that point, give a zero with the product sign. Rounding may carry a subnormal up into the smallest normal, 0x00800000.
- R8: If either operand is a NaN (exponent field 255, fraction non-zero), the result is 0x7FC00000.
- R9: Infinity times zero, in either order and with any signs, gives 0x7FC00000.
- R10: Infinity times a non-zero, non-NaN value gives infinity, and zero times a finite value gives zero. In both cases the sign is the XOR of the operand signs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers change on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks `op_a`/`op_b` as an operand pair to multiply |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_vld | output | 1 | Marks `out_res` as a product |
| out_res | output | 32 | Binary32 product |

## Verification
The bench builds the block with its default field widths: 8 exponent bits and 23 fraction bits. At these widths the exact significand product has at most 48 bits. A double-precision real therefore holds every product without error, so the reference model can form the true value and round it on its own. Directed pairs reach the largest finite value, the smallest subnormal, halfway ties in both regions, and the carry from the largest subnormal into the smallest normal. Randomised normal and subnormal pairs, with exponents aimed near both ends of the range, exercise the normalising and denormalising shifts.

// File: rtl/fpmul_pkg.sv
package fpmul_pkg;

    // Operand type codes; the normal code is 10x, this design emits 100
    typedef enum logic [2:0] {
        CLS_ZERO = 3'b000,
        CLS_SUB  = 3'b001,
        CLS_NORM = 3'b100,
        CLS_INF  = 3'b110,
        CLS_NAN  = 3'b111
    } fp_class_e;

endpackage

// File: rtl/fpmul_classify.sv
module fpmul_classify
    import fpmul_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output fp_class_e             cls,
    output logic [FRAC_W:0]       sig,
    output logic [EXP_W-1:0]      exp_eff
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_zero, exp_ones, frac_zero;

    always_comb begin
        exp_f     = op[FRAC_W +: EXP_W];
        frac_f    = op[FRAC_W-1:0];
        exp_zero  = (exp_f == '0);
        exp_ones  = &exp_f;
        frac_zero = (frac_f == '0);

        if (exp_zero && frac_zero)  cls = CLS_ZERO;
        else if (exp_zero)          cls = CLS_SUB;
        else if (exp_ones)          cls = frac_zero ? CLS_INF : CLS_NAN;
        else                        cls = CLS_NORM;

        // subnormals: hidden bit 0, exponent pinned at the minimum
        sig     = {!exp_zero, frac_f};
        exp_eff = exp_zero ? EXP_W'(1) : exp_f;
    end

endmodule

// File: rtl/fpmul_special.sv
module fpmul_special
    import fpmul_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  fp_class_e             cls_a,
    input  fp_class_e             cls_b,
    input  logic                  sign,
    output logic                  spec,
    output logic [EXP_W+FRAC_W:0] spec_res
);

    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic any_nan, any_inf, any_zero;

    always_comb begin
        any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
        any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
        any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
        spec     = any_nan || any_inf || any_zero;

        if (any_nan || (any_inf && any_zero)) spec_res = QNAN;
        else if (any_inf)                      spec_res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else                                   spec_res = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end

endmodule

// File: rtl/fpmul_round.sv
module fpmul_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                      sign,
    input  logic [2*FRAC_W+1:0]       prod,
    input  logic [EXP_W:0]            esum,
    output logic [EXP_W+FRAC_W:0]     res
);

    localparam int PROD_W = 2*FRAC_W + 2;
    localparam int PAD    = FRAC_W + 2;
    localparam int EXT_W  = PROD_W + PAD;
    localparam int LZ_W   = $clog2(PROD_W + 1);
    localparam int BE_W   = EXP_W + 4;
    localparam int BIAS   = (1 << (EXP_W-1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam int SH_MAX = PROD_W + 2;
    localparam int SH_W   = $clog2(SH_MAX + 1);
    localparam int MAG_W  = EXP_W + FRAC_W;

    logic [LZ_W-1:0]          lz;
    logic                     found;
    logic [PROD_W-1:0]        norm;
    logic signed [BE_W-1:0]   be, sh_full;
    logic [SH_W-1:0]          sh;
    logic [EXP_W-1:0]         expf;
    logic                     ovf, lost, guard, sticky, up;
    logic [EXT_W-1:0]         ext, shifted;
    logic [FRAC_W-1:0]        frac;
    logic [MAG_W-1:0]         mag;

    always_comb begin
        // leading-zero count over the whole product (subnormal inputs)
        lz    = '0;
        found = 1'b0;
        for (int i = PROD_W-1; i >= 0; i--) begin
            if (!found) begin
                if (prod[i]) found = 1'b1;
                else         lz = lz + LZ_W'(1);
            end
        end
        norm = prod << lz;

        be = $signed({{(BE_W-EXP_W-1){1'b0}}, esum})
           - $signed(BE_W'(BIAS - 1))
           - $signed({{(BE_W-LZ_W){1'b0}}, lz});

        sh_full = BE_W'(1 - be);
        if (be > 0) begin
            sh   = '0;
            expf = be[EXP_W-1:0];
            ovf  = (be >= EMAX);
        end else begin
            sh   = (sh_full > SH_MAX) ? SH_W'(SH_MAX) : sh_full[SH_W-1:0];
            expf = '0;
            ovf  = 1'b0;
        end

        // one right shift serves both denormalisation and the plain case
        ext     = {norm, {PAD{1'b0}}};
        shifted = ext >> sh;
        lost    = ((shifted << sh) != ext);
        frac    = shifted[EXT_W-2 -: FRAC_W];
        guard   = shifted[EXT_W-2-FRAC_W];
        sticky  = (|shifted[EXT_W-3-FRAC_W:0]) || lost;
        up      = guard && (sticky || frac[0]);

        // carry out of the fraction bumps the exponent field directly
        mag = {expf, frac} + MAG_W'(up);
        if (ovf || (&mag[MAG_W-1:FRAC_W]))
            res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            res = {sign, mag};
    end

endmodule

// File: rtl/fp_mult_sp.sv
module fp_mult_sp
    import fpmul_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_vld,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    output logic                  out_vld,
    output logic [EXP_W+FRAC_W:0] out_res
);

    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int ESUM_W = EXP_W + 1;
    localparam int BIAS   = (1 << (EXP_W-1)) - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic              vld;
        logic              spec;
        logic [W-1:0]      spec_res;
        logic              sign;
        fp_class_e         cls_a;
        fp_class_e         cls_b;
        logic [PROD_W-1:0] prod;
        logic [ESUM_W-1:0] esum;
    } stage1_t;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic [W-1:0]      ops     [2];
    fp_class_e         cls     [2];
    logic [SIG_W-1:0]  sig     [2];
    logic [EXP_W-1:0]  exp_eff [2];
    logic              sign_d, spec_d;
    logic [W-1:0]      spec_res_d, rnd_res;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign sign_d = op_a[W-1] ^ op_b[W-1];

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fpmul_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op      (ops[g]),
            .cls     (cls[g]),
            .sig     (sig[g]),
            .exp_eff (exp_eff[g])
        );
    end

    fpmul_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spec (
        .cls_a    (cls[0]),
        .cls_b    (cls[1]),
        .sign     (sign_d),
        .spec     (spec_d),
        .spec_res (spec_res_d)
    );

    fpmul_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
        .sign (pipe_q.s1.sign),
        .prod (pipe_q.s1.prod),
        .esum (pipe_q.s1.esum),
        .res  (rnd_res)
    );

    always_comb begin
        pipe_d             = pipe_q;
        pipe_d.s1.vld      = in_vld;
        pipe_d.s1.spec     = spec_d;
        pipe_d.s1.spec_res = spec_res_d;
        pipe_d.s1.sign     = sign_d;
        pipe_d.s1.cls_a    = cls[0];
        pipe_d.s1.cls_b    = cls[1];
        pipe_d.s1.prod     = PROD_W'(sig[0]) * PROD_W'(sig[1]);
        pipe_d.s1.esum     = ESUM_W'(exp_eff[0]) + ESUM_W'(exp_eff[1]);
        pipe_d.s2.vld      = pipe_q.s1.vld;
        pipe_d.s2.res      = pipe_q.s1.spec ? pipe_q.s1.spec_res : rnd_res;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_vld = pipe_q.s2.vld;
    assign out_res = pipe_q.s2.res;

    // ---------------- assertions ----------------
    logic s1_nan_case, s1_both_norm;
    always_comb begin
        s1_nan_case = (pipe_q.s1.cls_a == CLS_NAN) || (pipe_q.s1.cls_b == CLS_NAN)
                   || ((pipe_q.s1.cls_a == CLS_INF)  && (pipe_q.s1.cls_b == CLS_ZERO))
                   || ((pipe_q.s1.cls_a == CLS_ZERO) && (pipe_q.s1.cls_b == CLS_INF));
        s1_both_norm = (pipe_q.s1.cls_a == CLS_NORM) && (pipe_q.s1.cls_b == CLS_NORM);
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(in_vld, 2));

    // R8 R9
    canonical_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld && s1_nan_case |=> out_res == QNAN);

    // R3 R10
    sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld && !s1_nan_case |=> out_res[W-1] == $past(pipe_q.s1.sign));

    // R6
    overflow_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld && s1_both_norm && (pipe_q.s1.esum >= ESUM_W'(EMAX + BIAS))
        |=> out_res[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}});

    // R7
    underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld && s1_both_norm && (pipe_q.s1.esum <= ESUM_W'(BIAS - FRAC_W - 4))
        |=> out_res[W-2:0] == '0);

endmodule

// File: tb/fp_mult_sp_test.sv
`timescale 1ns/1ps
module fp_mult_sp_test;

    logic        clk = 1'b0;
    logic        rst_n, in_vld;
    logic [31:0] op_a, op_b;
    logic        out_vld;
    logic [31:0] out_res;

    always #2 clk = ~clk;

    fp_mult_sp uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
        .op_a(op_a), .op_b(op_b), .out_vld(out_vld), .out_res(out_res)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string cur_tag = "R3";

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: exact product as a double, then RNE to binary32
    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic              sg;
        logic              a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
        int                ma, mb, ea, eb;
        real               d;
        logic [63:0]       bits;
        longint            se, sh, res31;
        longint unsigned   sgf, kept, rem, half;
        logic [63:0]       r;
        sg     = a[31] ^ b[31];
        a_nan  = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        b_nan  = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        a_inf  = (a[30:23] == 8'hFF) && (a[22:0] == 0);
        b_inf  = (b[30:23] == 8'hFF) && (b[22:0] == 0);
        a_zero = (a[30:0] == 0);
        b_zero = (b[30:0] == 0);
        if (a_nan || b_nan)                        return 32'h7FC00000;
        if ((a_inf && b_zero) || (a_zero && b_inf)) return 32'h7FC00000;
        if (a_inf || b_inf)                        return {sg, 8'hFF, 23'h0};
        if (a_zero || b_zero)                      return {sg, 31'h0};
        ma = int'(a[22:0]) + ((a[30:23] != 0) ? (1 << 23) : 0);
        mb = int'(b[22:0]) + ((b[30:23] != 0) ? (1 << 23) : 0);
        ea = (a[30:23] == 0) ? 1 : int'(a[30:23]);
        eb = (b[30:23] == 0) ? 1 : int'(b[30:23]);
        d    = real'(ma) * real'(mb) * (2.0 ** real'(ea + eb - 300));
        bits = $realtobits(d);
        se   = longint'(bits[62:52]) - 1023 + 127;
        sgf  = {11'b0, 1'b1, bits[51:0]};
        sh   = (se >= 1) ? 29 : 29 + 1 - se;
        if (sh > 60) sh = 60;
        kept = sgf >> sh;
        rem  = sgf - (kept << sh);
        half = 64'd1 << (sh - 1);
        if ((rem > half) || ((rem == half) && kept[0])) kept = kept + 1;
        if (se >= 1) res31 = ((se - 1) <<< 23) + longint'(kept);
        else         res31 = longint'(kept);
        if (res31 >= (longint'(255) <<< 23)) return {sg, 8'hFF, 23'h0};
        r = res31;
        return {sg, r[30:0]};
    endfunction

    // Cycle monitor: compares both outputs after every rising edge
    logic        pv = 1'b0;
    logic [31:0] pa = '0, pb = '0, want;
    string       ptag = "R3";

    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            check(out_vld == pv, "R2", "out_vld", {31'b0, out_vld}, {31'b0, pv});
            if (pv) begin
                want = ref_mul(pa, pb);
                check(out_res === want, ptag, "out_res", out_res, want);
            end
        end
        pv   = in_vld && rst_n;
        pa   = op_a;
        pb   = op_b;
        ptag = cur_tag;
    end

    task automatic drive(input logic [31:0] a, input logic [31:0] b, input string t);
        @(negedge clk);
        in_vld  = 1'b1;
        op_a    = a;
        op_b    = b;
        cur_tag = t;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        rst_n  = 1'b0;
        in_vld = 1'b0;
        op_a   = '0;
        op_b   = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_vld == 1'b0, "R1", "out_vld in reset", {31'b0, out_vld}, 32'h0);
        check(out_res == 32'h0, "R1", "out_res in reset", out_res, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R3: plain normal products
        drive(32'h3FC00000, 32'h40000000, "R3");
        drive(32'hC0400000, 32'h3F000000, "R3");
        idle(1);
        // R4: halfway ties, one rounds up to even, one stays
        drive(32'h3F800001, 32'h3FC00000, "R4");
        drive(32'h3F800003, 32'h3FC00000, "R4");
        // R5: subnormal operands
        drive(32'h00000001, 32'h40000000, "R5");
        drive(32'h00400000, 32'h4B000000, "R5");
        drive(32'h807FFFFF, 32'h4B800000, "R5");
        // R6: overflow to signed infinity
        drive(32'h7F7FFFFF, 32'h40000000, "R6");
        drive(32'hFF7FFFFF, 32'h40000000, "R6");
        drive(32'h7F7FFFFF, 32'h3F800001, "R6");
        idle(2);
        // R7: underflow, ties at the bottom, carry into min normal, signed zero
        drive(32'h00800000, 32'h3F000000, "R7");
        drive(32'h00000001, 32'h3F000000, "R7");
        drive(32'h00000001, 32'h3F400000, "R7");
        drive(32'h00000003, 32'h3F000000, "R7");
        drive(32'h007FFFFF, 32'h3F800001, "R7");
        drive(32'h80000001, 32'h00000001, "R7");
        // R8: NaN operands
        drive(32'h7FC00000, 32'h3F800000, "R8");
        drive(32'h7F800001, 32'h00000000, "R8");
        drive(32'hFFFFFFFF, 32'h7F800000, "R8");
        // R9: infinity times zero
        drive(32'h7F800000, 32'h00000000, "R9");
        drive(32'h80000000, 32'hFF800000, "R9");
        // R10: other special pairs with sign XOR
        drive(32'hFF800000, 32'h3F800000, "R10");
        drive(32'h7F800000, 32'h00000001, "R10");
        drive(32'h7F800000, 32'hFF800000, "R10");
        drive(32'h80000000, 32'h40000000, "R10");
        drive(32'h00000000, 32'h80000005, "R10");
        idle(3);

        for (int i = 0; i < 200; i++) begin
            drive({1'($urandom), 8'($urandom_range(90, 165)), 23'($urandom)},
                  {1'($urandom), 8'($urandom_range(90, 165)), 23'($urandom)}, "R3");
            if (i % 7 == 0) idle(1);
        end
        for (int i = 0; i < 100; i++)
            drive({1'($urandom), 8'h00, 23'($urandom)},
                  {1'($urandom), 8'($urandom_range(100, 254)), 23'($urandom)}, "R5");
        for (int i = 0; i < 100; i++)
            drive({1'($urandom), 8'($urandom_range(180, 254)), 23'($urandom)},
                  {1'($urandom), 8'($urandom_range(180, 254)), 23'($urandom)}, "R6");
        for (int i = 0; i < 100; i++)
            drive({1'($urandom), 8'($urandom_range(1, 70)), 23'($urandom)},
                  {1'($urandom), 8'($urandom_range(40, 70)), 23'($urandom)}, "R7");
        for (int i = 0; i < 200; i++) begin
            drive($urandom, $urandom, "R3");
            if (i % 5 == 0) idle(2);
        end
        idle(4);
        finish_run();
    end

endmodule